// File: doc/BRIEF.md
# LCD Common Line Scanner

This block generates the line-by-line scan for a multiplexed graphic LCD. A 5-bit line counter names the display RAM line being shown. On each edge of the frame signal, in either direction, the counter is reloaded from a start-line register value. On each line clock pulse it steps forward by one. Because the start value is taken again at every frame, software can change it between frames to scroll the picture smoothly with no RAM copying.

The counter's upper two bits select a RAM page. The block outputs that page number and receives the page's 80 column bytes as one flat word. The lower three bits of the counter pick one bit from every byte, which gives 80 segment bits. The segment order can be reversed so that a panel can be routed either way. A separate common index counts the lines within a frame, up to a period of 16 or 32, and lights one common output at a time. The top level then applies the drive mode: blanked, static drive, or sleep.

Top module: `lcd_line_scanner`

## Requirements
- R1: Synchronous active-high reset clears the line counter, the common index and the stored frame level to 0. With `disp_on`=0 and `static_drv`=0 after reset, `rd_page` is 0, `seg_out` is all zero and `com_out` is 32'h1.
- R2: When `frame_sig` differs from its value at the previous clock edge, the next edge loads the line counter with `start_line` and clears the common index to 0.
- R3: On an edge where `line_tick`=1 and no frame edge occurs, the line counter steps by one modulo 32. `rd_page` always shows line counter bits [4:3].
- R4: The common index steps with the line counter and returns to 0 after index 31 when `duty_full`=1, or after index 15 when `duty_full`=0. In normal drive, `com_out` is one-hot at bit position equal to the index.
- R5: With `seg_rev`=0, `seg_out[n]` equals bit L of byte n of `rd_data`. Byte c occupies `rd_data[8c+7:8c]`, and L is line counter bits [2:0].
- R6: With `seg_rev`=1, `seg_out[n]` takes the same bit L from byte 79−n.
- R7: With `disp_on`=0 and `static_drv`=0, `seg_out` is all zero while the counters and `com_out` keep scanning.
- R8: With `static_drv`=1 and `disp_on`=1, every bit of `com_out` is 1 and the segments show RAM data as in R5/R6.
- R9: With `static_drv`=1 and `disp_on`=0 (sleep), `seg_out` and `com_out` are all zero. Line ticks and frame edges are ignored, so the counters resume from their frozen values when sleep ends.
- R10: When a frame edge and `line_tick` arrive in the same cycle, the reload of R2 wins over the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_tick | input | 1 | One-cycle line clock pulse |
| frame_sig | input | 1 | Frame signal; both edges start a frame |
| start_line | input | 5 | Scroll start line |
| duty_full | input | 1 | 1: 32-line frame, 0: 16-line frame |
| seg_rev | input | 1 | Reverse segment/column mapping |
| disp_on | input | 1 | Display enable |
| static_drv | input | 1 | Static drive request |
| rd_data | input | 640 | 80 column bytes of the addressed page |
| rd_page | output | 2 | Page being read |
| seg_out | output | 80 | Segment drive bits (1 = lit) |
| com_out | output | 32 | Common select bits |

## Verification
The line counter and the common index are registers, so a frame edge or a line tick takes effect on `rd_page`, `seg_out` and `com_out` one clock edge after it is seen. The mode inputs and `rd_data` act on the outputs combinationally, within the same cycle. The bench drives its inputs just after a falling edge. It advances its behavioural model on each rising edge. It compares all three outputs one nanosecond after the next falling edge, when both the registered and the combinational effects have settled.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int SEG_COUNT  = 80;
    localparam int COM_COUNT  = 32;
    localparam int BYTE_BITS  = 8;

    typedef enum logic [1:0] {
        DRV_SCAN,
        DRV_BLANK,
        DRV_STATIC,
        DRV_SLEEP
    } drive_mode_t;

    function automatic drive_mode_t pick_mode(input logic on, input logic stat);
        if (stat && !on)
            return DRV_SLEEP;
        else if (stat)
            return DRV_STATIC;
        else if (!on)
            return DRV_BLANK;
        return DRV_SCAN;
    endfunction

endpackage

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
    parameter int LINE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sig,
    input  logic              line_tick,
    input  logic              freeze,
    input  logic [LINE_W-1:0] start_line,
    output logic [LINE_W-1:0] line_cnt,
    output logic              frame_load
);
    logic fr_seen;

    assign frame_load = (frame_sig != fr_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_seen  <= 1'b0;
            line_cnt <= '0;
        end else begin
            fr_seen <= frame_sig;
            if (!freeze) begin
                if (frame_load)
                    line_cnt <= start_line;
                else if (line_tick)
                    line_cnt <= line_cnt + 1'b1;
            end
        end
    end

    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        (frame_load && !freeze) |=> (line_cnt == $past(start_line)));

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (line_tick && !frame_load && !freeze) |=> (line_cnt == LINE_W'($past(line_cnt) + 1'b1)));

    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(line_cnt));

endmodule

// File: rtl/lcd_com_sel.sv
module lcd_com_sel #(
    parameter int COMS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_load,
    input  logic            line_tick,
    input  logic            freeze,
    input  logic            duty_full,
    output logic [COMS-1:0] com_hot
);
    localparam int IDX_W = $clog2(COMS);
    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(COMS - 1);
    localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(COMS / 2 - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last;

    assign last = duty_full ? LAST_FULL : LAST_HALF;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (!freeze) begin
            if (frame_load)
                idx <= '0;
            else if (line_tick)
                idx <= (idx >= last) ? '0 : idx + 1'b1;
        end
    end

    for (genvar k = 0; k < COMS; k++) begin : g_dec
        assign com_hot[k] = (idx == IDX_W'(k));
    end

    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (line_tick && !frame_load && !freeze && idx == last) |=> (idx == '0));

    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        (frame_load && !freeze) |=> com_hot[0]);

endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map #(
    parameter int SEGS  = 80,
    parameter int BYTEW = 8
) (
    input  logic [SEGS*BYTEW-1:0]     row_bytes,
    input  logic [$clog2(BYTEW)-1:0]  bit_sel,
    input  logic                      reverse,
    output logic [SEGS-1:0]           seg_raw
);
    for (genvar n = 0; n < SEGS; n++) begin : g_seg
        localparam int COL_FWD = n;
        localparam int COL_REV = SEGS - 1 - n;
        logic [BYTEW-1:0] byte_fwd;
        logic [BYTEW-1:0] byte_rev;
        assign byte_fwd   = row_bytes[COL_FWD*BYTEW +: BYTEW];
        assign byte_rev   = row_bytes[COL_REV*BYTEW +: BYTEW];
        assign seg_raw[n] = reverse ? byte_rev[bit_sel] : byte_fwd[bit_sel];
    end

    always_comb begin
        a_r6_ends: assert (seg_raw[0] == (reverse ? row_bytes[(SEGS-1)*BYTEW + int'(bit_sel)]
                                                  : row_bytes[int'(bit_sel)]));
    end

endmodule

// File: rtl/lcd_line_scanner.sv
module lcd_line_scanner
    import lcd_scan_pkg::*;
#(
    parameter int SEGS  = SEG_COUNT,
    parameter int COMS  = COM_COUNT,
    parameter int BYTEW = BYTE_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   line_tick,
    input  logic                   frame_sig,
    input  logic [$clog2(COMS)-1:0] start_line,
    input  logic                   duty_full,
    input  logic                   seg_rev,
    input  logic                   disp_on,
    input  logic                   static_drv,
    input  logic [SEGS*BYTEW-1:0]  rd_data,
    output logic [$clog2(COMS)-$clog2(BYTEW)-1:0] rd_page,
    output logic [SEGS-1:0]        seg_out,
    output logic [COMS-1:0]        com_out
);
    localparam int LINE_W = $clog2(COMS);
    localparam int BIT_W  = $clog2(BYTEW);

    drive_mode_t       mode;
    logic              freeze;
    logic              frame_load;
    logic [LINE_W-1:0] line_cnt;
    logic [COMS-1:0]   com_hot;
    logic [SEGS-1:0]   seg_raw;

    assign mode   = pick_mode(disp_on, static_drv);
    assign freeze = (mode == DRV_SLEEP);

    lcd_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk(clk), .rst(rst), .frame_sig(frame_sig), .line_tick(line_tick),
        .freeze(freeze), .start_line(start_line),
        .line_cnt(line_cnt), .frame_load(frame_load)
    );

    lcd_com_sel #(.COMS(COMS)) u_com (
        .clk(clk), .rst(rst), .frame_load(frame_load), .line_tick(line_tick),
        .freeze(freeze), .duty_full(duty_full), .com_hot(com_hot)
    );

    lcd_seg_map #(.SEGS(SEGS), .BYTEW(BYTEW)) u_seg (
        .row_bytes(rd_data), .bit_sel(line_cnt[BIT_W-1:0]),
        .reverse(seg_rev), .seg_raw(seg_raw)
    );

    assign rd_page = line_cnt[LINE_W-1:BIT_W];

    always_comb begin
        unique case (mode)
            DRV_SCAN:   begin seg_out = seg_raw; com_out = com_hot;  end
            DRV_BLANK:  begin seg_out = '0;      com_out = com_hot;  end
            DRV_STATIC: begin seg_out = seg_raw; com_out = '1;       end
            default:    begin seg_out = '0;      com_out = '0;       end
        endcase
    end

    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (static_drv && !disp_on) |-> (seg_out == '0 && com_out == '0));

    a_r8_static: assert property (@(posedge clk) disable iff (rst)
        (static_drv && disp_on) |-> (com_out == '1));

    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        (!static_drv) |-> $onehot(com_out));

    a_r7_blank: assert property (@(posedge clk) disable iff (rst)
        (!disp_on) |-> (seg_out == '0));

endmodule

// File: tb/test_lcd_line_scanner.sv
module test_lcd_line_scanner;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         line_tick = 1'b0;
    logic         frame_sig = 1'b0;
    logic [4:0]   start_line = 5'd0;
    logic         duty_full = 1'b1;
    logic         seg_rev = 1'b0;
    logic         disp_on = 1'b0;
    logic         static_drv = 1'b0;
    logic [639:0] rd_data;
    logic [1:0]   rd_page;
    logic [79:0]  seg_out;
    logic [31:0]  com_out;

    int total = 0;
    int bad = 0;
    string tag = "R1";
    bit finished = 0;

    // reference state
    int m_line = 0;
    int m_idx  = 0;
    bit m_fr   = 0;

    always #4ns clk = ~clk;

    lcd_line_scanner i_lcd_line_scanner (
        .clk(clk), .rst(rst), .line_tick(line_tick), .frame_sig(frame_sig),
        .start_line(start_line), .duty_full(duty_full), .seg_rev(seg_rev),
        .disp_on(disp_on), .static_drv(static_drv), .rd_data(rd_data),
        .rd_page(rd_page), .seg_out(seg_out), .com_out(com_out)
    );

    function automatic logic [7:0] ram_byte(int page, int col);
        return 8'((page * 37 + col * 11 + 5) ^ (col << 3));
    endfunction

    always_comb begin
        for (int c = 0; c < 80; c++)
            rd_data[c*8 +: 8] = ram_byte(int'(rd_page), c);
    end

    always @(posedge clk) begin
        bit sleeping;
        bit edge_seen;
        int lim;
        sleeping  = static_drv && !disp_on;
        lim       = duty_full ? 31 : 15;
        if (rst) begin
            m_line <= 0; m_idx <= 0; m_fr <= 0;
        end else begin
            edge_seen = (frame_sig != m_fr);
            m_fr <= frame_sig;
            if (!sleeping) begin
                if (edge_seen) begin
                    m_line <= int'(start_line); m_idx <= 0;
                end else if (line_tick) begin
                    m_line <= (m_line + 1) % 32;
                    m_idx  <= (m_idx >= lim) ? 0 : m_idx + 1;
                end
            end
        end
    end

    task automatic check_outputs();
        logic [79:0] exp_seg;
        logic [31:0] exp_com;
        logic [1:0]  exp_page;
        bit sleeping;
        sleeping = static_drv && !disp_on;
        exp_page = 2'(m_line >> 3);
        for (int n = 0; n < 80; n++) begin
            int col;
            logic [7:0] b;
            col = seg_rev ? 79 - n : n;
            b = ram_byte(m_line >> 3, col);
            exp_seg[n] = b[m_line % 8];
        end
        if (!disp_on) exp_seg = '0;
        exp_com = 32'h1 << m_idx;
        if (static_drv) exp_com = '1;
        if (sleeping) exp_com = '0;
        total++;
        if (rd_page !== exp_page) begin
            bad++;
            $display("FAIL %s rd_page actual=%0d expected=%0d", tag, rd_page, exp_page);
        end
        total++;
        if (seg_out !== exp_seg) begin
            bad++;
            $display("FAIL %s seg_out actual=%h expected=%h", tag, seg_out, exp_seg);
        end
        total++;
        if (com_out !== exp_com) begin
            bad++;
            $display("FAIL %s com_out actual=%h expected=%h", tag, com_out, exp_com);
        end
    endtask

    // one clock step: compare after falling edge, then set inputs for next rising edge
    task automatic run(int cycles, int tick_period, int frame_period);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            #1ns;
            check_outputs();
            line_tick = (i % tick_period) == 0;
            if (frame_period > 0 && (i % frame_period) == frame_period - 1)
                frame_sig = ~frame_sig;
        end
        @(negedge clk); #1ns; check_outputs();
        line_tick = 1'b0;
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        tag = "R1";  run(3, 1000, 0);
        // R3: scan with page changes, 32-line frames
        disp_on = 1'b1;
        tag = "R3";  run(90, 2, 0);
        // R2: scroll start reloaded at both frame-edge directions
        start_line = 5'd13;
        tag = "R2";  run(140, 2, 64);
        // R4: half duty wrap at 16
        duty_full = 1'b0; start_line = 5'd27;
        tag = "R4";  run(120, 3, 0);
        duty_full = 1'b1;
        tag = "R4";  run(80, 1, 40);
        // R5: forward mapping at several lines
        tag = "R5";  run(40, 1, 0);
        // R6: reversed mapping
        seg_rev = 1'b1;
        tag = "R6";  run(60, 1, 25);
        // R7: blanked but scanning
        disp_on = 1'b0;
        tag = "R7";  run(50, 2, 30);
        // R8: static drive
        disp_on = 1'b1; static_drv = 1'b1;
        tag = "R8";  run(40, 2, 0);
        // R9: sleep ignores ticks and frame edges; resume from frozen values
        disp_on = 1'b0;
        tag = "R9";  run(40, 1, 7);
        disp_on = 1'b1; static_drv = 1'b0;
        tag = "R9";  run(20, 3, 0);
        // R10: frame edge and tick together
        start_line = 5'd5;
        tag = "R10"; run(60, 1, 9);
        seg_rev = 1'b0; start_line = 5'd31;
        tag = "R10"; run(40, 1, 6);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule